// File: doc/BRIEF.md
# SPI Register-Bank Peripheral Responder

This block is the device end of a two-phase SPI register protocol. A host first sends a one-byte command while a separate command-select line is held high. It then sends a data frame with that line low. The block remembers the last accepted command across the gap between the two frames. Each following data frame is then handled as that command's read or write.

The block holds eleven 32-bit banks:

- Bank 0 is a status register, built from a byte supplied by local logic.
- Banks 1 to 8 are per-channel configuration.
- Bank 9 is a fault register, taken from an input word.
- Bank 10 is a detection configuration.

Write data arrives lowest byte first. During a write, the response stream carries the live status byte, an echo of the command, and then zeros. Read data leaves highest byte first. A completed write is committed when chip select rises. It is reported on a one-cycle strobe with its address and value. The stored configuration banks are exposed as a flat output vector.

All SPI pins are sampled in the `clk` domain and must already be synchronous to it. SPI mode 0 is used: bits are sampled on the rising SCLK edge and changed on the falling edge. Bits within each byte travel most significant first. SPI has no flow control, so the block exerts no back-pressure. The write strobe is a fire-and-forget event that the receiving logic must accept in the cycle it appears.

Top module: `spi_rb_responder`

## Requirements
- R1: A frame that starts with `cmd_sel` high and carries exactly 8 bits is accepted as the command. In the command byte:
  - bit 7 = 1 selects write and 0 selects read;
  - bits 4:1 give the bank number;
  - bit 0 = 1 selects 8-bit mode and 0 selects 32-bit mode;
  - bits 6:5 are ignored.
- R2: During a command frame, `miso` shifts out `status_i` most significant bit first. `status_i` is captured when chip select falls, and the remaining bits of the frame are zero.
- R3: A 32-bit write data frame takes data byte [7:0] first, then [15:8], then [23:16], then [31:24]. Meanwhile `miso` returns the status byte, then the command byte, then 0x00 and 0x00.
- R4: A 32-bit read data frame returns the addressed bank on `miso`, highest byte first. Bank 0 reads as {24'h0, `status_i`} and bank 9 reads as `fault_i`.
- R5: In 8-bit mode, a write carries one byte that replaces only bits 31:24 of the bank. A read returns only bits 31:24.
- R6: Reading a configuration bank (1 to 8, or 10) returns exactly the last value written to it.
- R7: A write commits only when chip select rises after exactly the expected number of bits (32, or 8 in 8-bit mode). The commit appears as a single-cycle `wr_stb` with `wr_addr` and the full new `wr_data`. A shorter or longer frame changes nothing.
- R8: A command addressing a bank above 10 writes nothing, and a read of such a bank returns zeros.
- R9: Banks 0 and 9 are read-only. Writes to them produce no strobe and change no state.
- R10: `miso_oe` is low whenever `cs_n` is high.
- R11: Several data frames may follow one command, and each reuses it. A command frame that is not exactly 8 bits leaves the previous command in force. Before any command is accepted, a data frame returns zeros and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | SPI serial clock, synchronous to clk |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low chip select |
| cmd_sel | input | 1 | High during a command frame |
| status_i | input | 8 | Live status byte (bit 0 active, bit 1 undervoltage) |
| fault_i | input | 32 | Fault register contents |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso (high-impedance when low) |
| wr_stb | output | 1 | One-cycle write commit strobe |
| wr_addr | output | 4 | Bank written |
| wr_data | output | 32 | New full bank value |
| cfg_o | output | 288 | Banks 1..8 in slots 0..7, bank 10 in slot 8, 32 bits each |

## Verification
Assertions watch the following on every clock:

- the write strobe is one cycle wide and appears only with chip select released;
- the strobe never names banks 0, 9 or anything above 10;
- the stored banks hold still unless a commit occurs;
- the latched command changes only at the end of a command frame.

Other behaviour can only be shown by the bench's scenarios, using a behavioural model of the banks and the remembered command:

- byte ordering in both directions;
- the status and echo response;
- 8-bit merging;
- rejection of short and long frames;
- command persistence across the gap between frames.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int REG_W      = 32;
  localparam int BANK_W     = 4;
  localparam int STAT_W     = 8;
  localparam int STAT_BANK  = 0;
  localparam int FAULT_BANK = 9;
  localparam int DET_BANK   = 10;
  localparam int LAST_BANK  = 10;

  // Command byte layout; field positions are decoded by the host protocol.
  typedef struct packed {
    logic       wr;
    logic [1:0] rsv;
    logic [3:0] bank;
    logic       byte_mode;
  } cmd_t;

  function automatic logic [REG_W-1:0] swap_bytes(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    for (int i = 0; i < REG_W/8; i++) r[8*i +: 8] = v[REG_W-8-8*i +: 8];
    return r;
  endfunction
endpackage

// File: rtl/spi_rb_shifter.sv
module spi_rb_shifter #(
  parameter int FRAME_W = 32,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               mosi,
  input  logic               cs_n,
  input  logic [FRAME_W-1:0] load_word,
  output logic               sel_start,
  output logic               sel_end,
  output logic [FRAME_W-1:0] rx_word,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic               miso
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic               sclk_q, cs_q;
  logic               sclk_rise, sclk_fall;
  logic [FRAME_W-1:0] tx_q;

  assign sclk_rise = sclk & ~sclk_q & ~cs_n;
  assign sclk_fall = ~sclk & sclk_q & ~cs_n;
  assign sel_start = ~cs_n & cs_q;
  assign sel_end   = cs_n & ~cs_q;
  assign miso      = tx_q[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      tx_q    <= '0;
      rx_word <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (sel_start) begin
        tx_q    <= load_word;
        rx_word <= '0;
        bit_cnt <= '0;
      end else begin
        if (sclk_rise) begin
          rx_word <= {rx_word[FRAME_W-2:0], mosi};
          if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
        end
        if (sclk_fall) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
    end
  end

  p_count_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_start |=> (bit_cnt == '0));
endmodule

// File: rtl/spi_rb_regs.sv
module spi_rb_regs
  import spi_rb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [BANK_W-1:0]             wr_bank,
  input  logic [REG_W-1:0]              wr_data,
  input  logic [BANK_W-1:0]             rd_bank,
  input  logic [STAT_W-1:0]             status_i,
  input  logic [REG_W-1:0]              fault_i,
  output logic [REG_W-1:0]              rd_data,
  output logic [(NUM_CH+1)*REG_W-1:0]   cfg_o
);
  localparam int NUM_SLOT = NUM_CH + 1;

  function automatic logic [BANK_W-1:0] bank_of(input int slot);
    return (slot < NUM_CH) ? BANK_W'(slot + 1) : BANK_W'(DET_BANK);
  endfunction

  logic [REG_W-1:0] slot_q [NUM_SLOT];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (wr_en && wr_bank == bank_of(g)) slot_q[g] <= wr_data;
    end
    assign cfg_o[g*REG_W +: REG_W] = slot_q[g];
  end

  always_comb begin
    rd_data = '0;
    if (rd_bank == BANK_W'(STAT_BANK))       rd_data = {{(REG_W-STAT_W){1'b0}}, status_i};
    else if (rd_bank == BANK_W'(FAULT_BANK)) rd_data = fault_i;
    else begin
      for (int i = 0; i < NUM_SLOT; i++)
        if (rd_bank == bank_of(i)) rd_data = slot_q[i];
    end
  end

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_o));
endmodule

// File: rtl/spi_rb_responder.sv
module spi_rb_responder
  import spi_rb_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sclk,
  input  logic                        mosi,
  input  logic                        cs_n,
  input  logic                        cmd_sel,
  input  logic [7:0]                  status_i,
  input  logic [31:0]                 fault_i,
  output logic                        miso,
  output logic                        miso_oe,
  output logic                        wr_stb,
  output logic [3:0]                  wr_addr,
  output logic [31:0]                 wr_data,
  output logic [(NUM_CH+1)*32-1:0]    cfg_o
);
  localparam int CNT_W = 6;
  localparam logic [CNT_W-1:0] CMD_BITS  = CNT_W'(8);
  localparam logic [CNT_W-1:0] WORD_BITS = CNT_W'(REG_W);
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  logic             sel_start, sel_end;
  logic [REG_W-1:0] rx_word, load_word, rd_data, new_val;
  logic [CNT_W-1:0] bit_cnt;
  cmd_t             cmd_q;
  logic             cmd_vld, frame_cmd;
  logic             writable, commit;
  logic [CNT_W-1:0] need_bits;

  spi_rb_shifter #(.FRAME_W(REG_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .load_word(load_word), .sel_start(sel_start), .sel_end(sel_end),
    .rx_word(rx_word), .bit_cnt(bit_cnt), .miso(miso)
  );

  spi_rb_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_bank(cmd_q.bank),
    .wr_data(new_val), .rd_bank(cmd_q.bank), .status_i(status_i),
    .fault_i(fault_i), .rd_data(rd_data), .cfg_o(cfg_o)
  );

  assign writable  = (cmd_q.bank <= BANK_W'(LAST_BANK)) &&
                     (cmd_q.bank != BANK_W'(STAT_BANK)) &&
                     (cmd_q.bank != BANK_W'(FAULT_BANK));
  assign need_bits = cmd_q.byte_mode ? BYTE_BITS : WORD_BITS;
  assign new_val   = cmd_q.byte_mode ? {rx_word[7:0], rd_data[REG_W-9:0]}
                                     : swap_bytes(rx_word);
  assign commit    = sel_end && !frame_cmd && cmd_vld && cmd_q.wr &&
                     writable && (bit_cnt == need_bits);
  assign miso_oe   = ~cs_n;

  always_comb begin
    if (cmd_sel)       load_word = {status_i, {(REG_W-8){1'b0}}};
    else if (!cmd_vld) load_word = '0;
    else if (cmd_q.wr) load_word = {status_i, cmd_q, {(REG_W-16){1'b0}}};
    else               load_word = rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      cmd_vld   <= 1'b0;
      frame_cmd <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_stb <= commit;
      if (sel_start) frame_cmd <= cmd_sel;
      if (sel_end && frame_cmd && bit_cnt == CMD_BITS) begin
        cmd_q   <= cmd_t'(rx_word[7:0]);
        cmd_vld <= 1'b1;
      end
      if (commit) begin
        wr_addr <= cmd_q.bank;
        wr_data <= new_val;
      end
    end
  end

  p_strobe_deselected_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> cs_n);
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  p_ro_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr != 4'd0 && wr_addr != 4'd9 && wr_addr <= 4'd10));
  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_end && frame_cmd) |=> $stable(cmd_q));
endmodule

// File: tb/tb_spi_rb_responder.sv
module tb_spi_rb_responder;
  logic clk = 0, rst_n = 0, sclk = 0, mosi = 0, cs_n = 1, cmd_sel = 0;
  logic [7:0]  status_i = 8'h03;
  logic [31:0] fault_i  = 32'hDEAD_0F01;
  logic miso, miso_oe, wr_stb;
  logic [3:0] wr_addr;
  logic [31:0] wr_data;
  logic [287:0] cfg_o;

  spi_rb_responder dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mbank [0:10];
  logic [7:0]  mcmd = 0;
  bit          mvld = 0;
  logic [35:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R10 every clock; R7 strobe contents against the model queue
  always @(negedge clk) if (rst_n && !done) begin
    check(miso_oe == !cs_n, "R10 miso_oe", 64'(miso_oe), 64'(!cs_n));
    if (wr_stb) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected strobe", {28'h0, wr_addr, wr_data}, 0);
      else begin
        logic [35:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R7 strobe addr/data", 64'({wr_addr, wr_data}), 64'(e));
      end
    end
  end

  function automatic logic [31:0] mread(input int b);
    if (b == 0) return {24'h0, status_i};
    if (b == 9) return fault_i;
    if (b > 10) return 0;
    return mbank[b];
  endfunction

  function automatic logic [39:0] wbytes(input logic [31:0] v);
    return {8'h0, v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic run(input bit cl, input int n, input logic [39:0] d, input string req);
    logic [31:0] resp;
    logic [39:0] got, exp;
    logic [287:0] ecfg;
    bit w, b8;
    int bk;
    w = mcmd[7]; bk = mcmd[4:1]; b8 = mcmd[0];
    if (cl) resp = {status_i, 24'h0};
    else if (!mvld) resp = 0;
    else if (w) resp = {status_i, mcmd, 16'h0};
    else resp = mread(bk);
    // predict state change
    if (cl) begin
      if (n == 8) begin mcmd = d[7:0]; mvld = 1; end
    end else if (mvld && w && n == (b8 ? 8 : 32) && bk >= 1 && bk <= 10 && bk != 9) begin
      mbank[bk] = b8 ? {d[7:0], mbank[bk][23:0]} : {d[7:0], d[15:8], d[23:16], d[31:24]};
      exp_q.push_back({4'(bk), mbank[bk]});
    end
    // drive frame
    got = 0;
    @(negedge clk); cmd_sel = cl; cs_n = 0;
    repeat (3) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      got = {got[38:0], miso};
      mosi = d[i];
      repeat (2) @(negedge clk); sclk = 1;
      repeat (2) @(negedge clk); sclk = 0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1; cmd_sel = 0;
    repeat (4) @(negedge clk);
    exp = {resp, 8'h0} >> (40 - n);
    check(got == exp, {req, " miso"}, 64'(got), 64'(exp));
    for (int s = 0; s < 9; s++) ecfg[s*32 +: 32] = mbank[s < 8 ? s + 1 : 10];
    check(cfg_o == ecfg, {req, " banks"}, 64'(cfg_o ^ ecfg), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i <= 10; i++) mbank[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(miso_oe == 0 && wr_stb == 0, "R10 reset outputs", {miso_oe, wr_stb}, 0);
    check(cfg_o == 0, "R7 reset banks", 64'(cfg_o), 0);

    run(0, 32, 40'h0, "R11 data before command");
    run(1, 8, 40'h82, "R2 R1 cmd write bank1");
    run(0, 32, wbytes(32'h2850_0600), "R3 write bank1");
    status_i = 8'h01;
    run(1, 8, 40'h02, "R2 cmd read bank1");
    run(0, 32, 40'h0, "R4 R6 read bank1");
    run(0, 32, 40'h0, "R11 repeated read");
    run(1, 8, 40'h94, "R1 cmd write bank10");
    run(0, 32, wbytes(32'hCAFE_1234), "R3 write bank10");
    run(1, 8, 40'h14, "R1 cmd read bank10");
    run(0, 32, 40'h0, "R6 read bank10");
    run(1, 8, 40'h80, "R9 cmd write bank0");
    run(0, 32, wbytes(32'hFFFF_FFFF), "R9 write bank0 dropped");
    run(1, 8, 40'h00, "R4 cmd read bank0");
    run(0, 32, 40'h0, "R4 read status bank");
    run(1, 8, 40'h92, "R9 cmd write bank9");
    run(0, 32, wbytes(32'h1111_1111), "R9 write fault dropped");
    run(1, 8, 40'h12, "R4 cmd read bank9");
    run(0, 32, 40'h0, "R4 read fault bank");
    run(1, 8, 40'h84, "R1 cmd write bank2");
    run(0, 32, wbytes(32'h1122_3344), "R3 write bank2");
    run(1, 8, 40'h85, "R5 cmd 8-bit write bank2");
    run(0, 8, 40'hA5, "R5 8-bit write");
    run(0, 16, 40'h5A5A, "R7 short 8-bit frame");
    run(1, 8, 40'h04, "R5 cmd read bank2");
    run(0, 32, 40'h0, "R5 merged read");
    run(1, 8, 40'h05, "R5 cmd 8-bit read");
    run(0, 8, 40'h0, "R5 8-bit read");
    run(1, 8, 40'h86, "R7 cmd write bank3");
    run(0, 16, 40'hBEEF, "R7 short frame");
    run(0, 40, {wbytes(32'h7777_7777), 8'h0} | 40'h5, "R7 long frame");
    run(1, 8, 40'h98, "R8 cmd write bank12");
    run(0, 32, wbytes(32'h1234_5678), "R8 write bank12 dropped");
    run(1, 8, 40'h18, "R8 cmd read bank12");
    run(0, 32, 40'h0, "R8 read bank12 zeros");
    run(1, 5, 40'h03, "R11 short command frame");
    run(0, 32, 40'h0, "R11 old command kept");
    run(1, 8, 40'hE2, "R1 reserved bits set");
    run(0, 32, wbytes(32'h0A0B_0C0D), "R1 write bank1 via E2");
    run(1, 8, 40'h02, "R6 cmd read bank1");
    run(0, 32, 40'h0, "R6 read bank1 again");

    check(exp_q.size() == 0, "R7 missing strobes", 64'(exp_q.size()), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule